// File: doc/BRIEF.md
# Lightweight 80-bit sponge hash core

This core computes an 80-bit digest with a sponge construction over a 100-bit state. The state is a 5x5 matrix of 4-bit cells, each an element of GF(2^4) reduced by x^4 + x + 1. A feeder presents the message as 20-bit chunks on a valid/ready handshake and marks the final chunk with a last flag. Each accepted chunk is XORed into the top of the state, and a 12-round permutation then runs at one round per clock. The feeder pads the message before it reaches the core.

After the final chunk has been absorbed and permuted, the core squeezes out the digest 16 bits at a time. A full permutation separates consecutive squeezes. The assembled 80-bit value is presented with a one-cycle done pulse and held until the next digest. The state then returns to its initial value, so the next message can start at once.

Top module: `sponge_hash80`

## Requirements
- R1: While reset is asserted, and directly after it, `msg_ready` is 1, `hash_done` is 0 and `hash_out` is zero.
- R2: `msg_ready` is 0 while a permutation is running. A chunk or last flag offered while `msg_ready` is 0 is ignored and does not change the digest.
- R3: A chunk is accepted on a rising edge with `msg_valid` and `msg_ready` both high. For a chunk without the last flag, `msg_ready` returns to 1 after exactly 12 further rising edges.
- R4: Absorption XORs `msg_chunk` into the 20 most significant state bits. Row 0 is the top 20 bits, and cell (row r, column c) occupies bits [99-4(5r+c) -: 4]. The lower 80 bits are left unchanged.
- R5: Each round applies four steps in order. First, cell (r,0) is XORed with RC^IC[r], where IC = 0,1,3,6,4 and RC for rounds 1..12 is 1,3,7,E,D,B,6,C,9,2,5,A. Next, each cell is replaced through the S-box C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2 (indexed by the cell value). Then row r is rotated left by r cells. Finally, each column is multiplied by the matrix with rows [1 2 9 9 2], [2 5 3 8 D], [D B A C 1], [1 F 2 3 E], [E E 8 5 C].
- R6: After the last chunk, the core takes the top 16 state bits after each of five permutations. The first word taken becomes `hash_out[79:64]` and the fifth becomes `hash_out[15:0]`. `hash_done` rises exactly 60 rising edges after the edge that accepted the last chunk.
- R7: `hash_done` is a single-cycle pulse. `hash_out` changes only in the cycle `hash_done` is high and is held otherwise.
- R8: At reset and after every digest, the state is zero except its lowest 24 bits, which hold 0x14, 0x14 and 0x10 (digest width / 4, input rate, output rate). The same message therefore always yields the same digest, and `msg_ready` is 1 in the `hash_done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_valid | input | 1 | A chunk is offered |
| msg_ready | output | 1 | The core can take a chunk this cycle |
| msg_chunk | input | 20 | Message chunk |
| msg_last | input | 1 | The offered chunk is the final one |
| hash_done | output | 1 | One-cycle pulse: `hash_out` holds a new digest |
| hash_out | output | 80 | Digest, first squeezed word in the top bits |

## Verification
After the accepting edge, `msg_ready` is due back 12 edges later for an ordinary chunk. For a final chunk, `hash_done` and the new `hash_out` are due 60 edges later, and `hash_out` must otherwise stay put. The bench's reference model keeps a cycle countdown started at the same accepting edge and predicts `msg_ready`, `hash_done` and `hash_out` for every cycle. It computes the digest with its own table-driven arithmetic at the moment of acceptance. All three outputs are compared on each falling edge, so an early or late transition is caught in the exact cycle it occurs.

// File: rtl/sph_pkg.sv
package sph_pkg;

   // substitution table, entry x at nibble x counted from the top
   localparam logic [63:0]  SBOX_FLAT = 64'hC56B_90AD_3EF8_4712;
   // column-mix matrix, row-major, entry (0,0) in the top nibble
   localparam logic [99:0]  MDS_FLAT  = 100'h12992_2538D_DBAC1_1F23E_EE85C;
   // per-row constant added with the round value in column 0
   localparam logic [19:0]  ROWC_FLAT = 20'h01364;

   function automatic logic [3:0] sbox(input logic [3:0] x);
      return SBOX_FLAT[63 - 4*x -: 4];
   endfunction

   function automatic logic [3:0] mds(input int i, input int j);
      return MDS_FLAT[99 - 4*(i*5 + j) -: 4];
   endfunction

   function automatic logic [3:0] rowc(input int r);
      return ROWC_FLAT[19 - 4*r -: 4];
   endfunction

   // product in GF(2^4) modulo x^4 + x + 1
   function automatic logic [3:0] gf_mul(input logic [3:0] a, input logic [3:0] b);
      logic [3:0] p;
      logic [3:0] x;
      p = '0;
      x = a;
      for (int i = 0; i < 4; i++) begin
         if (b[i]) p = p ^ x;
         x = {x[2:0], 1'b0} ^ (x[3] ? 4'h3 : 4'h0);
      end
      return p;
   endfunction

endpackage

// File: rtl/sph_rcgen.sv
module sph_rcgen #(
   parameter int CELL_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              advance,
   output logic [CELL_W-1:0] rc
);
   logic [CELL_W-1:0] rc_q;
   logic [CELL_W-1:0] rc_nx;

   // shift left, feed back the inverted XOR of the two top bits
   assign rc_nx = {rc_q[CELL_W-2:0], ~(rc_q[CELL_W-1] ^ rc_q[CELL_W-2])};
   assign rc    = rc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rc_q <= CELL_W'(1);
      else if (restart) rc_q <= CELL_W'(1);
      else if (advance) rc_q <= rc_nx;
   end
endmodule

// File: rtl/sph_mixcol.sv
module sph_mixcol #(
   parameter int DIM    = 5,
   parameter int CELL_W = 4
) (
   input  logic [DIM*CELL_W-1:0] col_i,
   output logic [DIM*CELL_W-1:0] col_o
);
   import sph_pkg::*;

   always_comb begin
      col_o = '0;
      for (int i = 0; i < DIM; i++) begin
         for (int j = 0; j < DIM; j++) begin
            col_o[DIM*CELL_W-1-CELL_W*i -: CELL_W] = col_o[DIM*CELL_W-1-CELL_W*i -: CELL_W]
               ^ gf_mul(mds(i, j), col_i[DIM*CELL_W-1-CELL_W*j -: CELL_W]);
         end
      end
   end
endmodule

// File: rtl/sph_round.sv
module sph_round #(
   parameter int DIM    = 5,
   parameter int CELL_W = 4,
   localparam int ST_W  = DIM*DIM*CELL_W,
   localparam int COL_W = DIM*CELL_W
) (
   input  logic [ST_W-1:0]   st_i,
   input  logic [CELL_W-1:0] rc_i,
   output logic [ST_W-1:0]   st_o
);
   import sph_pkg::*;

   logic [CELL_W-1:0] sub_c [DIM][DIM];
   logic [COL_W-1:0]  col_in  [DIM];
   logic [COL_W-1:0]  col_out [DIM];

   for (genvar gr = 0; gr < DIM; gr++) begin : g_row
      for (genvar gc = 0; gc < DIM; gc++) begin : g_cell
         localparam int BIT_HI = ST_W - 1 - CELL_W*(gr*DIM + gc);
         logic [CELL_W-1:0] add_c;
         if (gc == 0) begin : g_col0
            assign add_c = st_i[BIT_HI -: CELL_W] ^ rc_i ^ rowc(gr);
         end else begin : g_rest
            assign add_c = st_i[BIT_HI -: CELL_W];
         end
         assign sub_c[gr][gc] = sbox(add_c);
         // row gr rotated left by gr places feeds column gc
         assign col_in[gc][COL_W-1-CELL_W*gr -: CELL_W] = sub_c[gr][(gc+gr)%DIM];
         assign st_o[BIT_HI -: CELL_W] = col_out[gc][COL_W-1-CELL_W*gr -: CELL_W];
      end
   end

   for (genvar gc = 0; gc < DIM; gc++) begin : g_mix
      sph_mixcol #(.DIM(DIM), .CELL_W(CELL_W)) u_mix (
         .col_i (col_in[gc]),
         .col_o (col_out[gc])
      );
   end
endmodule

// File: rtl/sponge_hash80.sv
module sponge_hash80 #(
   parameter int CELL_W   = 4,
   parameter int DIM      = 5,
   parameter int ROUNDS   = 12,
   parameter int RATE_IN  = 20,
   parameter int RATE_OUT = 16,
   parameter int DIGEST_W = 80
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                msg_valid,
   output logic                msg_ready,
   input  logic [RATE_IN-1:0]  msg_chunk,
   input  logic                msg_last,
   output logic                hash_done,
   output logic [DIGEST_W-1:0] hash_out
);
   localparam int STATE_W  = DIM*DIM*CELL_W;
   localparam int SQUEEZES = DIGEST_W / RATE_OUT;
   localparam int PART_W   = DIGEST_W - RATE_OUT;
   localparam int RND_W    = $clog2(ROUNDS + 1);
   localparam int SQ_W     = $clog2(SQUEEZES + 1);
   localparam logic [STATE_W-1:0] IV =
      STATE_W'({8'(DIGEST_W/4), 8'(RATE_IN), 8'(RATE_OUT)});

   if (CELL_W != 4 || DIM != 5) begin : g_bad_geom
      $error("sponge_hash80: constants are defined for 5x5 cells of 4 bits");
   end
   if (RATE_IN != DIM*CELL_W || RATE_OUT > RATE_IN) begin : g_bad_rate
      $error("sponge_hash80: rates must fit the top row");
   end
   if (DIGEST_W % RATE_OUT != 0 || SQUEEZES < 2 || ROUNDS < 1) begin : g_bad_dig
      $error("sponge_hash80: digest must be at least two whole squeezes");
   end

   logic [STATE_W-1:0]  st_q;
   logic [STATE_W-1:0]  st_nx;
   logic [CELL_W-1:0]   rc;
   logic                busy_q;
   logic                last_q;
   logic [RND_W-1:0]    rnd_q;
   logic [SQ_W-1:0]     sq_q;
   logic [PART_W-1:0]   part_q;
   logic                take;
   logic                perm_end;
   logic [RATE_OUT-1:0] sq_word;

   assign msg_ready = !busy_q;
   assign take      = msg_valid && !busy_q;
   assign perm_end  = busy_q && (rnd_q == RND_W'(ROUNDS - 1));
   assign sq_word   = st_nx[STATE_W-1 -: RATE_OUT];

   sph_rcgen #(.CELL_W(CELL_W)) u_rc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (take || perm_end),
      .advance (busy_q),
      .rc      (rc)
   );

   sph_round #(.DIM(DIM), .CELL_W(CELL_W)) u_round (
      .st_i (st_q),
      .rc_i (rc),
      .st_o (st_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= IV;
         busy_q    <= 1'b0;
         last_q    <= 1'b0;
         rnd_q     <= '0;
         sq_q      <= '0;
         part_q    <= '0;
         hash_out  <= '0;
         hash_done <= 1'b0;
      end else begin
         hash_done <= 1'b0;
         if (take) begin
            st_q   <= st_q ^ {msg_chunk, {(STATE_W-RATE_IN){1'b0}}};
            busy_q <= 1'b1;
            rnd_q  <= '0;
            last_q <= msg_last;
         end else if (busy_q) begin
            st_q  <= st_nx;
            rnd_q <= rnd_q + RND_W'(1);
            if (perm_end) begin
               rnd_q <= '0;
               if (!last_q) begin
                  busy_q <= 1'b0;
               end else if (sq_q == SQ_W'(SQUEEZES - 1)) begin
                  busy_q    <= 1'b0;
                  last_q    <= 1'b0;
                  sq_q      <= '0;
                  hash_done <= 1'b1;
                  hash_out  <= {part_q, sq_word};
                  st_q      <= IV;
               end else begin
                  sq_q   <= sq_q + SQ_W'(1);
                  part_q <= PART_W'({part_q, sq_word});
               end
            end
         end
      end
   end
endmodule

// File: rtl/sponge_hash80_chk.sv
module sponge_hash80_chk #(
   parameter int ROUNDS   = 12,
   parameter int SQUEEZES = 5,
   parameter int DIGEST_W = 80
) (
   input logic                clk,
   input logic                rst_n,
   input logic                msg_valid,
   input logic                msg_ready,
   input logic                msg_last,
   input logic                hash_done,
   input logic [DIGEST_W-1:0] hash_out
);
   logic [15:0] busy_cnt;
   logic        last_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_cnt  <= '0;
         last_seen <= 1'b0;
      end else if (msg_valid && msg_ready) begin
         busy_cnt  <= '0;
         last_seen <= msg_last;
      end else if (!msg_ready) begin
         busy_cnt  <= busy_cnt + 16'd1;
      end
   end

   p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_ready) |=> !msg_ready);

   p_ready_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_ready) |-> (busy_cnt == (last_seen ? 16'(ROUNDS*SQUEEZES) : 16'(ROUNDS))));

   p_done_timing_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hash_done |-> (last_seen && busy_cnt == 16'(ROUNDS*SQUEEZES)));

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hash_done |=> !hash_done);

   p_digest_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !hash_done |-> $stable(hash_out));

   p_done_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hash_done |-> msg_ready);
endmodule

bind sponge_hash80 sponge_hash80_chk #(
   .ROUNDS   (ROUNDS),
   .SQUEEZES (DIGEST_W / RATE_OUT),
   .DIGEST_W (DIGEST_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .msg_valid (msg_valid),
   .msg_ready (msg_ready),
   .msg_last  (msg_last),
   .hash_done (hash_done),
   .hash_out  (hash_out)
);

// File: tb/tb_sponge_hash80.sv
`timescale 1ns/1ps
module tb_sponge_hash80;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        msg_valid = 1'b0;
   logic        msg_ready;
   logic [19:0] msg_chunk = '0;
   logic        msg_last = 1'b0;
   logic        hash_done;
   logic [79:0] hash_out;

   always #2 clk = ~clk;   // 250 MHz

   sponge_hash80 dut (
      .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
      .msg_chunk(msg_chunk), .msg_last(msg_last), .hash_done(hash_done), .hash_out(hash_out)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   task automatic chk(string tag, logic [79:0] act, logic [79:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference ----------------
   int SB[16]    = '{12,5,6,11,9,0,10,13,3,14,15,8,4,7,1,2};
   int RCT[12]   = '{1,3,7,14,13,11,6,12,9,2,5,10};
   int ICT[5]    = '{0,1,3,6,4};
   int MM[5][5]  = '{'{1,2,9,9,2}, '{2,5,3,8,13}, '{13,11,10,12,1},
                     '{1,15,2,3,14}, '{14,14,8,5,12}};
   int m[5][5];

   function automatic int gm(int a, int b);
      int p = 0;
      int x = a;
      for (int i = 0; i < 4; i++) begin
         if (((b >> i) & 1) != 0) p = p ^ x;
         x = x << 1;
         if ((x & 16) != 0) x = x ^ 19;
      end
      return p;
   endfunction

   task automatic m_init();
      logic [23:0] iv = 24'h141410;
      for (int i = 0; i < 5; i++)
         for (int j = 0; j < 5; j++) m[i][j] = 0;
      for (int k = 19; k < 25; k++) m[k/5][k%5] = int'((iv >> (4*(24-k))) & 24'hF);
   endtask

   task automatic m_perm();
      int t[5];
      for (int r = 0; r < 12; r++) begin
         for (int i = 0; i < 5; i++) m[i][0] = m[i][0] ^ RCT[r] ^ ICT[i];
         for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++) m[i][j] = SB[m[i][j]];
         for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 5; j++) t[j] = m[i][(j+i)%5];
            for (int j = 0; j < 5; j++) m[i][j] = t[j];
         end
         for (int j = 0; j < 5; j++) begin
            for (int i = 0; i < 5; i++) begin
               t[i] = 0;
               for (int k = 0; k < 5; k++) t[i] = t[i] ^ gm(MM[i][k], m[k][j]);
            end
            for (int i = 0; i < 5; i++) m[i][j] = t[i];
         end
      end
   endtask

   int          remain;
   logic        exp_ready;
   logic        exp_done;
   logic [79:0] exp_dig;
   logic [79:0] pend_dig;
   bit          pend;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_init();
         remain = 0; exp_done = 1'b0; exp_dig = '0; pend = 1'b0; pend_dig = '0;
      end else begin
         exp_done = 1'b0;
         if (remain == 0 && msg_valid) begin
            for (int j = 0; j < 5; j++)
               m[0][j] = m[0][j] ^ int'((msg_chunk >> (4*(4-j))) & 20'hF);
            m_perm();
            if (msg_last) begin
               pend_dig = '0;
               for (int s = 0; s < 5; s++) begin
                  pend_dig = {pend_dig[63:0], 4'(m[0][0]), 4'(m[0][1]), 4'(m[0][2]), 4'(m[0][3])};
                  if (s < 4) m_perm();
               end
               pend = 1'b1;
               m_init();
               remain = 60;
            end else begin
               remain = 12;
            end
         end else if (remain > 0) begin
            remain--;
            if (remain == 0 && pend) begin
               exp_done = 1'b1; exp_dig = pend_dig; pend = 1'b0;
            end
         end
      end
      exp_ready = (remain == 0);
   end

   // compare every cycle, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && cyc > 0) begin
         chk("R2 R3 ready", 80'(msg_ready), 80'(exp_ready));
         chk("R6 R7 done", 80'(hash_done), 80'(exp_done));
         chk("R7 digest hold", hash_out, exp_dig);
         if (exp_done) chk("R4 R5 R6 R8 digest", hash_out, exp_dig);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog act=%0d exp=<100000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic send(logic [19:0] d, bit last, bit poke);
      @(negedge clk);
      msg_valid = 1'b1; msg_chunk = d; msg_last = last;
      while (!msg_ready) @(negedge clk);
      @(negedge clk);
      if (poke) begin
         // R2: junk offered while busy must be ignored
         for (int k = 0; k < 4; k++) begin
            msg_chunk = ~d ^ 20'(k); msg_last = 1'b1;
            @(negedge clk);
         end
      end
      msg_valid = 1'b0; msg_last = 1'b0;
   endtask

   task automatic wait_done(output logic [79:0] dg);
      while (!hash_done) @(negedge clk);
      dg = hash_out;
      @(negedge clk);
   endtask

   logic [79:0] d_a1, d_a2, d_b, d_z;

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset ready", 80'(msg_ready), 80'd1);
      chk("R1 reset done", 80'(hash_done), 80'd0);
      chk("R1 reset digest", hash_out, 80'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset ready", 80'(msg_ready), 80'd1);

      send(20'h12345, 1'b1, 1'b0);
      wait_done(d_a1);

      send(20'hABCDE, 1'b0, 1'b1);
      send(20'h01234, 1'b0, 1'b0);
      send(20'hFFFFF, 1'b0, 1'b1);
      send(20'h00000, 1'b1, 1'b1);
      wait_done(d_b);

      send(20'h12345, 1'b1, 1'b0);
      wait_done(d_a2);
      chk("R8 same message same digest", d_a2, d_a1);
      n_chk++;
      if (d_a1 === d_b) begin
         n_fail++;
         $display("FAIL R4 distinct messages act=%h exp=differs from %h", d_b, d_a1);
      end

      send(20'h00000, 1'b1, 1'b0);
      wait_done(d_z);
      n_chk++;
      if (d_z === d_a1) begin
         n_fail++;
         $display("FAIL R4 zero chunk act=%h exp=differs from %h", d_z, d_a1);
      end

      repeat (5) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule